// File: doc/BRIEF.md
# Carry-chained corrective vector adder

This block finishes the second pass of a big-integer multiply-subtract. The first pass leaves two vectors of 64-bit half results. This block reads one element from each vector per cycle, pairs them as the upper and lower halves of a 128-bit value, and adds a running 64-bit scalar carry plus a 128-bit all-ones constant. The constant makes the step the same as adding the carry and then subtracting one. The low 64 bits of the sum go out on a register-write port as the result for that element. The high 64 bits become the next carry, with one added when the incoming carry is 0 or 1.

Software loads the carry, which is normally zero, together with the start pulse and the vector length. Each element uses the carry produced by the element before it, so elements are taken strictly in ascending order, one per cycle. The block drives the read index, and the register file answers in the same cycle. When the last element has been written, a one-cycle done pulse is raised and the updated carry can be read at the carry output.

Top module: `vec_carry_fixup`

## Requirements
- R1: While reset is asserted and right after it, wr_en_o, busy_o and done_o are low and carry_o is zero.
- R2: A start_i pulse accepted while the block is not busy loads carry_i into the carry register. With a nonzero length, busy_o is high in the next cycle, with element index 0.
- R3: Element k is presented in the k-th busy cycle after start. In that cycle rd_idx_o and wr_idx_o both equal k, wr_en_o is high, and indices rise by one each cycle with none skipped or repeated.
- R4: wr_data_o equals bits 63:0 of ({hi_i, lo_i} + zero-extended carry + 2^128-1) mod 2^128. Here hi_i is the upper half, and the carry is the value held at that time.
- R5: The carry for the next element is bits 127:64 of the same sum, plus one if the held carry is 0 or 1 as an unsigned value. The increment wraps modulo 2^64.
- R6: done_o is high for one cycle, in the cycle after the last write, and busy_o is low in that cycle. carry_o then shows the final carry and keeps it until the next accepted start.
- R7: start_i raised while busy_o is high is ignored. It changes neither the element sequence, the write data nor the final carry.
- R8: A vl_i of zero produces no write, and done_o is high in the next cycle with carry_o equal to the loaded carry_i.
- R9: Exactly min(vl_i, MAX_VL) elements are written, so a vl_i above MAX_VL is clamped to MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when the block is not busy |
| vl_i | input | VL_W | Vector length, clamped to MAX_VL |
| carry_i | input | 64 | Initial carry loaded on start |
| rd_idx_o | output | IDX_W | Element index to read from both source vectors |
| hi_i | input | 64 | Upper-half element at rd_idx_o, same cycle |
| lo_i | input | 64 | Lower-half element at rd_idx_o, same cycle |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | IDX_W | Destination element index |
| wr_data_o | output | 64 | Destination element value |
| busy_o | output | 1 | Elements in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 64 | Carry register, final value valid with done_o |

## Verification
The hardest case to reach from the ports is the carry bump when the incoming carry is 0 or 1, together with the wrap of that bump. These only show up as the carry chains from one element to the next. The bench sets the initial carry to 0, 1, 2 and all-ones. It also fills the source vectors with all-zero pairs, so that the sum is all ones and the bumped carry wraps to zero, which then feeds the next element with carry 0 again. It also raises start in the middle of a run, and starts a new run in the same cycle as a done pulse.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int unsigned XLEN = 64;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [2*XLEN-1:0] dword_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  typedef struct packed {
    word_t res;
    word_t carry;
  } step_t;
endpackage

// File: rtl/vcf_step.sv
module vcf_step
  import vcf_pkg::*;
(
  input  word_t hi_i,
  input  word_t lo_i,
  input  word_t carry_i,
  output step_t out_o
);
  dword_t cat, ext, sum;
  word_t  hi_sum;
  logic   bump;

  always_comb begin
    cat    = {hi_i, lo_i};
    ext    = {{XLEN{1'b0}}, carry_i};
    // all-ones constant: net effect is carry - 1
    sum    = cat + ext + {(2*XLEN){1'b1}};
    bump   = (carry_i <= word_t'(1));
    hi_sum = sum[2*XLEN-1:XLEN];
    out_o.res   = sum[XLEN-1:0];
    out_o.carry = hi_sum + {{(XLEN-1){1'b0}}, bump};
  end
endmodule

// File: rtl/vcf_seq.sv
module vcf_seq
  import vcf_pkg::*;
#(
  parameter int unsigned MAX_VL = 8,
  parameter int unsigned VL_W   = 4,
  parameter int unsigned IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [VL_W-1:0] MAX_VL_V = VL_W'(MAX_VL);

  state_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [VL_W-1:0]  vl_eff;

  always_comb begin
    vl_eff  = (vl_i > MAX_VL_V) ? MAX_VL_V : vl_i;
    load_o  = start_i && (state_q != ST_RUN);
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    unique case (state_q)
      ST_RUN: begin
        if (idx_q == last_q) state_d = ST_DONE;
        else                 idx_d   = idx_q + IDX_W'(1);
      end
      default: begin
        state_d = ST_IDLE;
        if (load_o) begin
          idx_d   = '0;
          last_d  = IDX_W'(vl_eff - VL_W'(1));
          state_d = (vl_eff == '0) ? ST_DONE : ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign idx_o  = idx_q;
endmodule

// File: rtl/vec_carry_fixup.sv
module vec_carry_fixup
  import vcf_pkg::*;
#(
  parameter int unsigned MAX_VL = 8,
  parameter int unsigned VL_W   = 4,
  parameter int unsigned IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [XLEN-1:0]  carry_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [XLEN-1:0]  hi_i,
  input  logic [XLEN-1:0]  lo_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]  wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [XLEN-1:0]  carry_o
);
  logic             load, busy;
  logic [IDX_W-1:0] idx;
  word_t            carry_q;
  step_t            step;

  vcf_seq #(
    .MAX_VL(MAX_VL),
    .VL_W  (VL_W),
    .IDX_W (IDX_W)
  ) seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .vl_i   (vl_i),
    .load_o (load),
    .busy_o (busy),
    .idx_o  (idx),
    .done_o (done_o)
  );

  vcf_step step_i (
    .hi_i   (hi_i),
    .lo_i   (lo_i),
    .carry_i(carry_q),
    .out_o  (step)
  );

  // carry register: input and in-place output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   carry_q <= '0;
    else if (load) carry_q <= carry_i;
    else if (busy) carry_q <= step.carry;
  end

  assign rd_idx_o  = idx;
  assign wr_idx_o  = idx;
  assign wr_en_o   = busy;
  assign wr_data_o = step.res;
  assign busy_o    = busy;
  assign carry_o   = carry_q;
endmodule

// File: rtl/vcf_chk.sv
module vcf_chk
  import vcf_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [XLEN-1:0]  carry_o
);
  p_first_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (wr_idx_o == '0));

  p_busy_from_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o == $past(wr_idx_o) + IDX_W'(1)));

  p_done_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !wr_en_o));

  p_carry_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(carry_o));
endmodule

bind vec_carry_fixup vcf_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .wr_en_o (wr_en_o),
  .wr_idx_o(wr_idx_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .carry_o (carry_o)
);

// File: tb/vec_carry_fixup_tb_top.sv
module vec_carry_fixup_tb_top;
  localparam int MAX_VL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  vl = '0;
  logic [63:0] carry_in = '0;
  logic [2:0]  rd_idx, wr_idx;
  logic [63:0] hi, lo, wr_data, carry_out;
  logic        wr_en, busy, done;
  logic [63:0] hi_mem [MAX_VL];
  logic [63:0] lo_mem [MAX_VL];
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign hi = hi_mem[rd_idx];
  assign lo = lo_mem[rd_idx];

  vec_carry_fixup dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl), .carry_i(carry_in),
    .rd_idx_o(rd_idx), .hi_i(hi), .lo_i(lo), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done), .carry_o(carry_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of one element: value minus one plus carry
  task automatic model(input logic [63:0] h, input logic [63:0] l, input logic [63:0] c,
                       output logic [63:0] res, output logic [63:0] nc);
    logic [127:0] v;
    v = {h, l} - 128'd1 + {64'd0, c};
    res = v[63:0];
    nc = v[127:64];
    if (c < 64'd2) nc = nc + 64'd1;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < MAX_VL; i++) begin
      hi_mem[i] = {$urandom, $urandom};
      lo_mem[i] = {$urandom, $urandom};
    end
  endtask

  // caller is at a negedge; poke >= 0 raises start mid-run at that element
  task automatic run_op(input int vlen, input logic [63:0] c0, input int poke);
    int n;
    logic [63:0] c, res, nc;
    n = (vlen > MAX_VL) ? MAX_VL : vlen;
    c = c0;
    vl = 4'(vlen);
    carry_in = c0;
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
      model(hi_mem[k], lo_mem[k], c, res, nc);
      chk(wr_en == 1'b1 && busy == 1'b1, "R2/R3 wr_en", 64'(wr_en), 64'd1);
      chk(wr_idx == 3'(k) && rd_idx == 3'(k), "R3 index", 64'(wr_idx), 64'(k));
      chk(wr_data == res, "R4 data", wr_data, res);
      chk(carry_out == c, "R5 chained carry", carry_out, c);
      chk(done == 1'b0, "R6 done early", 64'(done), 64'd0);
      c = nc;
      if (k == poke) begin
        start = 1'b1;
        vl = 4'd2;
        carry_in = 64'hDEAD_BEEF_0BAD_F00D;
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R6/R8 done", 64'(done), 64'd1);
    chk(wr_en == 1'b0 && busy == 1'b0, "R9 no extra write", 64'(wr_en), 64'd0);
    chk(carry_out == c, "R6 final carry", carry_out, c);
  endtask

  initial begin
    for (int i = 0; i < MAX_VL; i++) begin
      hi_mem[i] = '0;
      lo_mem[i] = '0;
    end
    @(negedge clk);
    chk(wr_en == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", 64'(wr_en), 64'd0);
    chk(carry_out == 64'd0, "R1 reset carry", carry_out, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b0 && done == 1'b0 && carry_out == 64'd0, "R1 after reset", carry_out, 64'd0);

    fill_rand();
    run_op(1, 64'd0, -1);
    run_op(8, 64'd1, -1);
    run_op(8, 64'd2, -1);
    run_op(8, 64'hFFFF_FFFF_FFFF_FFFF, -1);
    // all-zero pairs: sum all ones, bumped carry wraps to zero (R5)
    for (int i = 0; i < MAX_VL; i++) begin
      hi_mem[i] = '0;
      lo_mem[i] = '0;
    end
    run_op(6, 64'd0, -1);
    run_op(4, 64'd1, -1);
    fill_rand();
    run_op(0, 64'h1234_5678_9ABC_DEF0, -1);   // R8
    run_op(12, 64'd0, -1);                    // R9 clamp
    run_op(7, 64'd5, 2);                      // R7 start while busy
    run_op(3, 64'd0, 2);                      // R7 at last element
    for (int t = 0; t < 24; t++) begin
      fill_rand();
      case (t % 4)
        0: run_op(1 + (t % 8), 64'd0, -1);
        1: run_op(1 + (t % 8), 64'd1, -1);
        2: run_op(1 + (t % 8), {$urandom, $urandom}, -1);
        default: run_op(1 + (t % 8), 64'hFFFF_FFFF_FFFF_FFFF, -1);
      endcase
    end
    @(negedge clk);
    chk(done == 1'b0 && wr_en == 1'b0, "R6 single pulse", 64'(done), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule